// File: doc/BRIEF.md
# Row-wise sparse product dispatcher

This block sits at both ends of a row-by-row sparse matrix product C = A·B. One row of A at a time comes in as a stream of nonzero pairs (the row index k into B and the value a). The block hands each pair to one of several parallel processing elements (PEs). Each PE scales row k of B by a and returns the scaled row as (column, value) beats, closed by one end marker. The block adds the returned partials into a bounded dense accumulator indexed by column. When every dispatched pair has sent its end marker, it emits the finished output row in compressed form.

Only one output row is in flight at a time. While a row is being collected, both dispatch and return traffic are live. While the row is being emitted, the input is held off. The PEs and the fetch of B rows lie outside the block. Values are integers that wrap at the value width.

Top module: `rowdisp_top`

## Requirements
- R1: Each output row equals the sum, over the nonzeros (k, a) of the matching input row, of a times row k of B, with integer arithmetic wrapping at VW bits.
- R2: An accepted nonzero is issued in the same cycle to exactly one PE that shows peFree high. peIssue is a one-hot pulse, and issueRow/issueVal carry k and a.
- R3: Dispatch is round-robin. The first pick after reset is the lowest-numbered free PE. Each later pick is the first free PE with a higher index than the previous pick, wrapping back to index 0.
- R4: A row's output starts only after its nonzero marked aLast has been accepted and one end marker (peOutEnd high) has come back for each nonzero issued. No nonzero of the next row is accepted before the current row's final output beat.
- R5: Output beats of a row come in strictly increasing column order, one beat per distinct column touched, with outLast high on the final beat only.
- R6: Partials that share a column are summed into one beat. Column indices must be below NCOLS.
- R7: A row whose returned partials contain no products is emitted as a single beat with outEmpty and outLast both high.
- R8: aReady is low whenever no PE is free.
- R9: After reset, outValid and peIssue are low and aReady is high once some PE is free.
- R10: At most one return beat is taken per cycle. peOutReady is one-hot, goes only to a PE with peOutValid high, and is granted round-robin among the valid PEs in the same way as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aValid | input | 1 | Input nonzero available |
| aReady | output | 1 | Input nonzero accepted this cycle when high with aValid |
| aCol | input | IW | Index k of the B row for this nonzero |
| aVal | input | VW | Value of this nonzero |
| aLast | input | 1 | Marks the last nonzero of the row |
| peFree | input | NPE | PE can take a new nonzero |
| peIssue | output | NPE | One-hot issue strobe |
| issueRow | output | IW | B row index sent with the issue |
| issueVal | output | VW | A value sent with the issue |
| peOutValid | input | NPE | PE return beat available |
| peOutReady | output | NPE | Return beat taken (one-hot) |
| peOutCol | input | NPE*IW | Per-PE column of the return beat |
| peOutVal | input | NPE*VW | Per-PE product value of the return beat |
| peOutEnd | input | NPE | Return beat is the end marker, with no data |
| outValid | output | 1 | Output beat valid |
| outCol | output | IW | Output column |
| outVal | output | VW | Accumulated value |
| outLast | output | 1 | Final beat of the row |
| outEmpty | output | 1 | Row has no entries |

## Verification
The bench drives random rows through PE models whose availability is randomly withheld. It also uses directed rows that cover cases the random rows may miss: more nonzeros than PEs, rows that touch only an empty B row, and columns at both ends of the accumulator. A wrong dispatch or return arbiter shows up as an issue or grant to the wrong PE, checked on every transfer. A missed completion count shows up as an output row that starts early or sums too little, or as a next-row issue before the last beat. An accumulator that overwrites instead of adding gives wrong sums on shared columns. A faulty scan gives beats out of order, a misplaced outLast, or a missing empty marker.

// File: rtl/rowdisp_pkg.sv
package rowdisp_pkg;
  typedef struct packed {
    logic accWe;     // add selected return beat into its column slot
    logic emit;      // emit slot at scan index and clear it
    logic emitEmpty; // emit the empty-row marker beat
  } ctrlStrobe_t;
endpackage

// File: rtl/rowdisp_ctrl.sv
module rowdisp_ctrl
  import rowdisp_pkg::*;
#(
  parameter int NPE     = 4,
  parameter int NCOLS   = 16,
  parameter int NNZ_MAX = 64,
  localparam int SW     = $clog2(NPE),
  localparam int CXW    = $clog2(NCOLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aValid,
  input  logic             aLast,
  output logic             aReady,
  input  logic [NPE-1:0]   peFree,
  output logic [NPE-1:0]   peIssue,
  input  logic [NPE-1:0]   peOutValid,
  input  logic [NPE-1:0]   peOutEnd,
  output logic [NPE-1:0]   peOutReady,
  output logic [SW-1:0]    retSel,
  output logic [CXW-1:0]   scanIdx,
  input  logic             anyPresent,
  input  logic             presentHere,
  input  logic             lastHere,
  output ctrlStrobe_t      strobe
);
  localparam int CW = $clog2(NNZ_MAX + 1);

  typedef enum logic {ST_GATHER, ST_SCAN} state_t;

  state_t        state;
  logic [SW-1:0] issPtr, retPtr, issIdx, retIdx;
  logic [CW-1:0] issuedCnt, endCnt;
  logic          lastSeen, inGather, issueFire, retFire, retIsEnd, rowDone, scanEnd;

  function automatic logic [SW-1:0] rrPick(input logic [NPE-1:0] req, input logic [SW-1:0] last);
    logic [SW-1:0] pick;
    logic found;
    pick  = last;
    found = 1'b0;
    for (int i = 1; i <= NPE; i++) begin
      int j;
      j = (int'(last) + i) % NPE;
      if (!found && req[j]) begin
        pick  = SW'(j);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  always_comb begin
    issIdx     = rrPick(peFree, issPtr);
    retIdx     = rrPick(peOutValid, retPtr);
    inGather   = (state == ST_GATHER);
    aReady     = inGather && !lastSeen && (|peFree);
    issueFire  = aValid && aReady;
    peIssue    = issueFire ? (NPE'(1) << issIdx) : '0;
    retFire    = inGather && (|peOutValid);
    peOutReady = retFire ? (NPE'(1) << retIdx) : '0;
    retSel     = retIdx;
    retIsEnd   = peOutEnd[retIdx];
    rowDone    = inGather && lastSeen && (issuedCnt == endCnt);
    strobe.accWe     = retFire && !retIsEnd;
    strobe.emitEmpty = (state == ST_SCAN) && !anyPresent;
    strobe.emit      = (state == ST_SCAN) && anyPresent && presentHere;
    scanEnd          = strobe.emitEmpty || (strobe.emit && lastHere);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_GATHER;
      issPtr    <= SW'(NPE - 1);
      retPtr    <= SW'(NPE - 1);
      issuedCnt <= '0;
      endCnt    <= '0;
      lastSeen  <= 1'b0;
      scanIdx   <= '0;
    end else if (inGather) begin
      if (issueFire) begin
        issPtr    <= issIdx;
        issuedCnt <= issuedCnt + CW'(1);
        if (aLast) lastSeen <= 1'b1;
      end
      if (retFire) begin
        retPtr <= retIdx;
        if (retIsEnd) endCnt <= endCnt + CW'(1);
      end
      if (rowDone) begin
        state   <= ST_SCAN;
        scanIdx <= '0;
      end
    end else begin
      if (scanEnd) begin
        state     <= ST_GATHER;
        issuedCnt <= '0;
        endCnt    <= '0;
        lastSeen  <= 1'b0;
      end else begin
        scanIdx <= scanIdx + CXW'(1);
      end
    end
  end

  AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(peIssue)); // R2
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(peOutReady)); // R10
  AST_ENDS_BOUNDED: assert property (@(posedge clk) disable iff (!rstN) endCnt <= issuedCnt); // R4
  AST_SCAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (peOutValid == '0)); // R4
endmodule

// File: rtl/rowdisp_datapath.sv
module rowdisp_datapath
  import rowdisp_pkg::*;
#(
  parameter int NPE   = 4,
  parameter int VW    = 32,
  parameter int IW    = 32,
  parameter int NCOLS = 16,
  localparam int SW   = $clog2(NPE),
  localparam int CXW  = $clog2(NCOLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SW-1:0]     retSel,
  input  logic [CXW-1:0]    scanIdx,
  input  logic [NPE*IW-1:0] peOutCol,
  input  logic [NPE*VW-1:0] peOutVal,
  output logic              anyPresent,
  output logic              presentHere,
  output logic              lastHere,
  output logic              outValid,
  output logic [IW-1:0]     outCol,
  output logic [VW-1:0]     outVal,
  output logic              outLast,
  output logic              outEmpty
);
  logic [VW-1:0]    accMem [NCOLS];
  logic [NCOLS-1:0] present, aboveMask;
  logic [IW-1:0]    selCol;
  logic [VW-1:0]    selVal;
  logic [CXW-1:0]   accIdx;

  always_comb begin
    selCol = peOutCol[retSel*IW +: IW];
    selVal = peOutVal[retSel*VW +: VW];
    accIdx = selCol[CXW-1:0];
    for (int i = 0; i < NCOLS; i++) aboveMask[i] = (i > int'(scanIdx));
    anyPresent  = |present;
    presentHere = present[scanIdx];
    lastHere    = presentHere && !(|(present & aboveMask));
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        present[c] <= 1'b0;
        accMem[c]  <= '0;
      end else if (strobe.accWe && accIdx == CXW'(c)) begin
        accMem[c]  <= present[c] ? accMem[c] + selVal : selVal;
        present[c] <= 1'b1;
      end else if (strobe.emit && scanIdx == CXW'(c)) begin
        present[c] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCol   <= '0;
      outVal   <= '0;
      outLast  <= 1'b0;
      outEmpty <= 1'b0;
    end else begin
      outValid <= strobe.emit || strobe.emitEmpty;
      outCol   <= strobe.emit ? {{(IW-CXW){1'b0}}, scanIdx} : '0;
      outVal   <= strobe.emit ? accMem[scanIdx] : '0;
      outLast  <= strobe.emit ? lastHere : strobe.emitEmpty;
      outEmpty <= strobe.emitEmpty;
    end
  end

  // ordering monitor for the output stream
  logic          inRow;
  logic [IW-1:0] prevCol;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inRow   <= 1'b0;
      prevCol <= '0;
    end else if (outValid) begin
      inRow   <= !outLast;
      prevCol <= outCol;
    end
  end

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accWe |-> (selCol < IW'(NCOLS))); // R6
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && inRow) |-> (outCol > prevCol)); // R5
  AST_EMPTY_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && inRow) |-> !outEmpty); // R7
endmodule

// File: rtl/rowdisp_top.sv
module rowdisp_top
  import rowdisp_pkg::*;
#(
  parameter int NPE     = 4,
  parameter int VW      = 32,
  parameter int IW      = 32,
  parameter int NCOLS   = 16,
  parameter int NNZ_MAX = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  output logic              aReady,
  input  logic [IW-1:0]     aCol,
  input  logic [VW-1:0]     aVal,
  input  logic              aLast,
  input  logic [NPE-1:0]    peFree,
  output logic [NPE-1:0]    peIssue,
  output logic [IW-1:0]     issueRow,
  output logic [VW-1:0]     issueVal,
  input  logic [NPE-1:0]    peOutValid,
  output logic [NPE-1:0]    peOutReady,
  input  logic [NPE*IW-1:0] peOutCol,
  input  logic [NPE*VW-1:0] peOutVal,
  input  logic [NPE-1:0]    peOutEnd,
  output logic              outValid,
  output logic [IW-1:0]     outCol,
  output logic [VW-1:0]     outVal,
  output logic              outLast,
  output logic              outEmpty
);
  localparam int SW  = $clog2(NPE);
  localparam int CXW = $clog2(NCOLS);

  ctrlStrobe_t    strobe;
  logic [SW-1:0]  retSel;
  logic [CXW-1:0] scanIdx;
  logic           anyPresent, presentHere, lastHere;

  assign issueRow = aCol;
  assign issueVal = aVal;

  rowdisp_ctrl #(.NPE(NPE), .NCOLS(NCOLS), .NNZ_MAX(NNZ_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aLast(aLast), .aReady(aReady),
    .peFree(peFree), .peIssue(peIssue), .peOutValid(peOutValid), .peOutEnd(peOutEnd),
    .peOutReady(peOutReady), .retSel(retSel), .scanIdx(scanIdx),
    .anyPresent(anyPresent), .presentHere(presentHere), .lastHere(lastHere), .strobe(strobe)
  );

  rowdisp_datapath #(.NPE(NPE), .VW(VW), .IW(IW), .NCOLS(NCOLS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retSel(retSel), .scanIdx(scanIdx),
    .peOutCol(peOutCol), .peOutVal(peOutVal), .anyPresent(anyPresent),
    .presentHere(presentHere), .lastHere(lastHere), .outValid(outValid),
    .outCol(outCol), .outVal(outVal), .outLast(outLast), .outEmpty(outEmpty)
  );
endmodule

// File: tb/rowdisp_top_bench.sv
module rowdisp_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPE = 4, VW = 32, IW = 32, NCOLS = 16;
  localparam int NK = 8, BMAX = 6, NROWS = 30;

  logic clk = 1'b0, rstN = 1'b0;
  logic aValid = 1'b0, aLast = 1'b0, aReady;
  logic [IW-1:0] aCol = '0, issueRow, outCol;
  logic [VW-1:0] aVal = '0, issueVal, outVal;
  logic [NPE-1:0] peFree = '0, peIssue, peOutValid = '0, peOutReady, peOutEnd = '0;
  logic [NPE*IW-1:0] peOutCol = '0;
  logic [NPE*VW-1:0] peOutVal = '0;
  logic outValid, outLast, outEmpty;

  always #(CLK_PERIOD/2) clk = ~clk;

  rowdisp_top #(.NPE(NPE), .VW(VW), .IW(IW), .NCOLS(NCOLS)) u_rowdisp_top (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aReady(aReady), .aCol(aCol), .aVal(aVal),
    .aLast(aLast), .peFree(peFree), .peIssue(peIssue), .issueRow(issueRow), .issueVal(issueVal),
    .peOutValid(peOutValid), .peOutReady(peOutReady), .peOutCol(peOutCol), .peOutVal(peOutVal),
    .peOutEnd(peOutEnd), .outValid(outValid), .outCol(outCol), .outVal(outVal),
    .outLast(outLast), .outEmpty(outEmpty)
  );

  int total = 0, bad = 0;
  int bCnt [NK];
  logic [31:0] bCol [NK][BMAX];
  logic [31:0] bVal [NK][BMAX];
  int aN = 0, aPtr = 0;
  logic [31:0] aKs [256];
  logic [31:0] aVs [256];
  logic aLs [256];
  int aRow [256];
  int expN = 0, outPtr = 0, rowsOut = 0;
  logic [31:0] expCol [1024];
  logic [31:0] expVal [1024];
  logic expLast [1024];
  logic expEmp [1024];
  logic busy [NPE];
  logic [31:0] pk [NPE];
  logic [31:0] pv [NPE];
  int pDelay [NPE], pj [NPE];
  int issPtrM = NPE - 1, retPtrM = NPE - 1;
  bit randomFree = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rrModel(input logic [NPE-1:0] req, input int last);
    for (int i = 1; i <= NPE; i++) if (req[(last + i) % NPE]) return (last + i) % NPE;
    return -1;
  endfunction

  task automatic addRow(input int r, input int n, input int ks[8], input logic [31:0] vs[8]);
    logic [31:0] sum [NCOLS];
    bit hit [NCOLS];
    int lastC;
    bit any;
    for (int c = 0; c < NCOLS; c++) begin sum[c] = 0; hit[c] = 0; end
    for (int i = 0; i < n; i++) begin
      aKs[aN] = ks[i]; aVs[aN] = vs[i]; aLs[aN] = (i == n - 1); aRow[aN] = r; aN++;
      for (int j = 0; j < bCnt[ks[i]]; j++) begin
        sum[bCol[ks[i]][j]] += vs[i] * bVal[ks[i]][j];
        hit[bCol[ks[i]][j]] = 1;
      end
    end
    any = 0; lastC = -1;
    for (int c = 0; c < NCOLS; c++) if (hit[c]) begin any = 1; lastC = c; end
    if (!any) begin
      expCol[expN] = 0; expVal[expN] = 0; expLast[expN] = 1; expEmp[expN] = 1; expN++;
    end else begin
      for (int c = 0; c < NCOLS; c++) if (hit[c]) begin
        expCol[expN] = c; expVal[expN] = sum[c]; expLast[expN] = (c == lastC);
        expEmp[expN] = 0; expN++;
      end
    end
  endtask

  initial begin
    int ks[8];
    logic [31:0] vs[8];
    int cycles;
    void'($urandom(32'd20240611));
    // B rows: 0..4 random over columns 0..7, 5 -> column 0, 6 -> column 15, 7 empty
    for (int k = 0; k < 5; k++) begin
      bCnt[k] = 1 + int'($urandom_range(0, BMAX - 1));
      for (int j = 0; j < bCnt[k]; j++) begin
        bCol[k][j] = $urandom_range(0, 7); bVal[k][j] = $urandom_range(1, 50);
      end
    end
    bCnt[5] = 1; bCol[5][0] = 0;  bVal[5][0] = 3;
    bCnt[6] = 2; bCol[6][0] = 15; bVal[6][0] = 7; bCol[6][1] = 15; bVal[6][1] = 32'hFFFF_FFFF;
    bCnt[7] = 0;
    for (int k = 0; k < NK; k++) for (int j = bCnt[k]; j < BMAX; j++) begin bCol[k][j] = 0; bVal[k][j] = 0; end
    // directed rows
    for (int i = 0; i < 8; i++) begin ks[i] = 0; vs[i] = 0; end
    for (int i = 0; i < 6; i++) begin ks[i] = i % 5; vs[i] = i + 2; end
    addRow(0, 6, ks, vs);                         // more nonzeros than PEs
    ks[0] = 7; vs[0] = 9; addRow(1, 1, ks, vs);   // empty output
    ks[0] = 7; ks[1] = 7; addRow(2, 2, ks, vs);   // empty output, two nonzeros
    ks[0] = 6; vs[0] = 32'h8000_0001; ks[1] = 5; vs[1] = 5; addRow(3, 2, ks, vs); // edge columns, wrap
    for (int r = 4; r < NROWS; r++) begin
      int n;
      n = $urandom_range(1, 8);
      for (int i = 0; i < n; i++) begin
        ks[i] = $urandom_range(0, NK - 1);
        vs[i] = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(1, 100));
      end
      addRow(r, n, ks, vs);
    end
    for (int p = 0; p < NPE; p++) begin busy[p] = 0; pk[p] = 0; pv[p] = 0; pDelay[p] = 0; pj[p] = 0; end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    peFree = '1;
    #1;
    check(outValid == 1'b0, "R9", "outValid after reset", outValid, 0);
    check(peIssue == '0, "R9", "peIssue after reset", peIssue, 0);
    check(aReady == 1'b1, "R9", "aReady after reset", aReady, 1);

    cycles = 0;
    while (rowsOut < NROWS && cycles < 50000) begin
      @(negedge clk);
      cycles++;
      if (rowsOut >= 4) randomFree = 1'b1;
      // output observation
      if (outValid) begin
        if (outPtr < expN) begin
          check(outCol == expCol[outPtr], "R5", "output column", outCol, expCol[outPtr]);
          check(outVal == expVal[outPtr], "R1", "output value", outVal, expVal[outPtr]);
          check(outLast == expLast[outPtr], "R5", "outLast", outLast, expLast[outPtr]);
          check(outEmpty == expEmp[outPtr], "R7", "outEmpty", outEmpty, expEmp[outPtr]);
          if (expLast[outPtr]) rowsOut++;
        end else check(1'b0, "R5", "extra output beat", outPtr, expN);
        outPtr++;
      end
      // drive inputs
      aValid = (aPtr < aN);
      aCol = aValid ? aKs[aPtr] : '0;
      aVal = aValid ? aVs[aPtr] : '0;
      aLast = aValid ? aLs[aPtr] : 1'b0;
      for (int p = 0; p < NPE; p++) begin
        peFree[p] = !busy[p] && (!randomFree || $urandom_range(0, 3) != 0);
        peOutValid[p] = 1'b0; peOutEnd[p] = 1'b0;
        peOutCol[p*IW +: IW] = '0; peOutVal[p*VW +: VW] = '0;
        if (busy[p]) begin
          if (pDelay[p] > 0) pDelay[p]--;
          else if ($urandom_range(0, 3) != 0) begin
            peOutValid[p] = 1'b1;
            if (pj[p] < bCnt[pk[p]]) begin
              peOutCol[p*IW +: IW] = bCol[pk[p]][pj[p]];
              peOutVal[p*VW +: VW] = pv[p] * bVal[pk[p]][pj[p]];
            end else peOutEnd[p] = 1'b1;
          end
        end
      end
      #(CLK_PERIOD/2 - 1);
      // transfers at the coming edge
      if (peFree == '0 && aValid) check(aReady == 1'b0, "R8", "aReady with no free PE", aReady, 0);
      if (aValid && aReady) begin
        int e;
        e = rrModel(peFree, issPtrM);
        check(peIssue == (NPE'(1) << e), "R3", "issue target", peIssue, NPE'(1) << e);
        check(issueRow == aKs[aPtr] && issueVal == aVs[aPtr], "R2", "issue payload", issueRow, aKs[aPtr]);
        check(aRow[aPtr] == rowsOut, "R4", "row of accepted nonzero", aRow[aPtr], rowsOut);
        if (e >= 0) begin
          busy[e] = 1; pk[e] = aKs[aPtr]; pv[e] = aVs[aPtr];
          pDelay[e] = $urandom_range(0, 3); pj[e] = 0; issPtrM = e;
        end
        aPtr++;
      end else begin
        check(peIssue == '0, "R2", "issue without accept", peIssue, 0);
      end
      if (peOutReady != '0 || peOutValid != '0) begin
        if (peOutReady != '0) begin
          int g;
          g = rrModel(peOutValid, retPtrM);
          check(peOutReady == (NPE'(1) << g), "R10", "return grant", peOutReady, NPE'(1) << g);
          if (g >= 0 && peOutReady[g]) begin
            retPtrM = g;
            if (peOutEnd[g]) busy[g] = 0; else pj[g]++;
          end
        end
      end
    end
    check(cycles < 50000, "R4", "watchdog rows completed", rowsOut, NROWS);
    check(outPtr == expN, "R5", "total output beats", outPtr, expN);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule